// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block produces the system reset for a chip from two digital events: a comparator bit that reports whether the supply is above its trip level, and a one-cycle strobe that reports a watchdog expiry. Reset is active from the moment the block comes out of power-on reset. It stays active until the supply indication has been good without a break for a programmable number of millisecond ticks. Any supply dip restarts that wait in full. A watchdog expiry forces the same kind of timed reset pulse.

The supply bit arrives asynchronously and passes through a flop synchronizer first. A prescaled one-millisecond tick input times every delay. The reset pad is open-drain. It is modelled as a level plus an output-enable, and the active level is chosen by a parameter.

The controller is a four-state machine. The states are:

- `ST_SUPPLY_LOW`: supply not good, counter held clear.
- `ST_QUALIFY`: supply good, release countdown running.
- `ST_RUN`: reset released.
- `ST_WDOG_HOLD`: reset forced after a watchdog expiry.

The transitions are:

- LOW→QUALIFY when the synchronized supply is good.
- QUALIFY→LOW and RUN→LOW and WDOG_HOLD→LOW when the synchronized supply drops. This has priority over every other transition.
- QUALIFY→RUN and WDOG_HOLD→RUN when the countdown completes.
- RUN→WDOG_HOLD on a watchdog strobe.
- A strobe seen in QUALIFY or WDOG_HOLD restarts the countdown and keeps the state.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first release, reset is active. This holds whatever the supply and watchdog inputs do.
- R2: When `supply_ok_raw` falls, reset becomes active at the third rising clock edge after the change. This holds from any state.
- R3: With the supply good and a tick on every cycle, reset is released at the (RELEASE_MS+3)th rising edge after `supply_ok_raw` rises, starting from the supply-low state. In general, release needs RELEASE_MS ticks counted while qualifying.
- R4: A supply dip of any length during the countdown clears it. After the supply returns, the full delay of R3 is needed again.
- R5: A `wdt_expire` strobe while released makes reset active at the next edge. With a tick on every cycle, reset is released again at the (RELEASE_MS+1)th edge after the strobe.
- R6: A further strobe during the watchdog hold, or during supply qualification, restarts the countdown from zero.
- R7: A supply dip during the watchdog hold discards the hold. Release then follows the full supply qualification of R3.
- R8: With ACTIVE_HIGH=0, `rst_level` is 0 while reset is active and 1 otherwise. With ACTIVE_HIGH=1, it is the opposite. `rst_oe` is 1 exactly while reset is active.
- R9: A `wdt_expire` strobe while the supply is not good has no effect. The qualification latency of R3 is unchanged.
- R10: Ticks count only when `ms_tick` is high. With no tick, reset is never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| supply_ok_raw | input | 1 | Comparator bit, 1 = supply above trip, asynchronous |
| wdt_expire | input | 1 | One-cycle watchdog expiry strobe |
| rst_level | output | 1 | Level the reset pad drives when enabled |
| rst_oe | output | 1 | Open-drain enable, 1 while reset is active |

## Verification
The bench targets the following corner cases, and each maps to a specific failure in a wrong design:

- A one-cycle supply dip in the middle of a countdown. A design that only pauses the counter would release early.
- A supply dip during a watchdog hold. A wrong design would release on the watchdog schedule instead of the full qualification.
- A repeated strobe during a hold. A design that ignores it would release one hold after the first strobe.
- Strobes while the supply is low. A design that honours them could enter the watchdog state and shorten qualification.

The exact release latencies for supply rise and watchdog strobe are checked edge by edge. This catches an extra or missing synchronizer stage, or an off-by-one terminal count. Long random runs with sparse ticks are compared with a reference model. Both pad polarities are checked side by side.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    typedef enum logic [1:0] {
        ST_SUPPLY_LOW = 2'd0,
        ST_QUALIFY    = 2'd1,
        ST_RUN        = 2'd2,
        ST_WDOG_HOLD  = 2'd3
    } ssr_state_e;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ssr_hold_counter.sv
module ssr_hold_counter #(
    parameter int RELEASE_MS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int CW = (RELEASE_MS > 1) ? $clog2(RELEASE_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(RELEASE_MS - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && !clear && tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (clear || !run)   cnt_q <= '0;
        else if (tick) begin
            if (cnt_q == LAST)    cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
        end
    end

    // Counter stays inside its window
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // A clear request always empties the count: dips restart the delay
    assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt_q == '0);
    // Without a tick the count cannot advance
    assert_no_tick_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/ssr_reset_fsm.sv
module ssr_reset_fsm
    import ssr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sup_ok,
    input  logic wdt,
    input  logic cnt_done,
    output logic cnt_run,
    output logic cnt_clear,
    output logic rst_active
);
    ssr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SUPPLY_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SUPPLY_LOW: if (sup_ok) state_d = ST_QUALIFY;
            ST_QUALIFY: begin
                if (!sup_ok)       state_d = ST_SUPPLY_LOW;
                else if (wdt)      state_d = ST_QUALIFY;
                else if (cnt_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!sup_ok)       state_d = ST_SUPPLY_LOW;
                else if (wdt)      state_d = ST_WDOG_HOLD;
            end
            ST_WDOG_HOLD: begin
                if (!sup_ok)       state_d = ST_SUPPLY_LOW;
                else if (wdt)      state_d = ST_WDOG_HOLD;
                else if (cnt_done) state_d = ST_RUN;
            end
        endcase
    end

    always_comb begin
        cnt_run    = 1'b0;
        cnt_clear  = 1'b1;
        rst_active = 1'b1;
        unique case (state_q)
            ST_SUPPLY_LOW: ;
            ST_QUALIFY, ST_WDOG_HOLD: begin
                cnt_run   = 1'b1;
                cnt_clear = !sup_ok || wdt;
            end
            ST_RUN: rst_active = 1'b0;
        endcase
    end

    // Supply drop forces reset at the following edge
    assert_drop_asserts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok |=> state_q == ST_SUPPLY_LOW);
    // Release only on a completed countdown
    assert_release_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_RUN) |-> $past(cnt_done));
    // Watchdog strobe while running enters the watchdog hold
    assert_wdt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sup_ok && wdt) |=> state_q == ST_WDOG_HOLD);
    // Strobe during supply-low has no effect on the state
    assert_wdt_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUPPLY_LOW && !sup_ok) |=> state_q == ST_SUPPLY_LOW);
endmodule

// File: rtl/ssr_pad_drive.sv
module ssr_pad_drive #(
    parameter bit ACTIVE_HIGH = 1'b0
) (
    input  logic active,
    output logic level,
    output logic oe
);
    generate
        if (ACTIVE_HIGH) begin : g_high
            assign level = active;
        end else begin : g_low
            assign level = !active;
        end
    endgenerate
    assign oe = active;
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
    parameter int RELEASE_MS  = 200,
    parameter int SYNC_STAGES = 2,
    parameter bit ACTIVE_HIGH = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic supply_ok_raw,
    input  logic wdt_expire,
    output logic rst_level,
    output logic rst_oe
);
    localparam logic ACT_LVL = ACTIVE_HIGH;

    logic sup_ok, cnt_run, cnt_clear, cnt_done, rst_active;

    ssr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(supply_ok_raw), .dout(sup_ok));

    ssr_hold_counter #(.RELEASE_MS(RELEASE_MS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(cnt_run), .clear(cnt_clear),
        .tick(ms_tick), .done(cnt_done));

    ssr_reset_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .wdt(wdt_expire),
        .cnt_done(cnt_done), .cnt_run(cnt_run), .cnt_clear(cnt_clear),
        .rst_active(rst_active));

    ssr_pad_drive #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_pad (
        .active(rst_active), .level(rst_level), .oe(rst_oe));

    // Pad enabled only while driving the active level
    assert_oe_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_oe |-> rst_level == ACT_LVL);
    assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_oe |-> rst_level != ACT_LVL);
    // First cycle after power-on reset is always in reset
    assert_por_active_R1: assert property (@(posedge clk)
        !rst_n |-> rst_oe);
endmodule

// File: tb/supply_reset_seq_tb.sv
module supply_reset_seq_tb;
    localparam int REL = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0;
    logic supply_ok_raw = 1'b0;
    logic wdt_expire = 1'b0;
    logic lvl_lo, oe_lo, lvl_hi, oe_hi;

    int n_checks = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    supply_reset_seq #(.RELEASE_MS(REL), .ACTIVE_HIGH(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .supply_ok_raw(supply_ok_raw),
        .wdt_expire(wdt_expire), .rst_level(lvl_lo), .rst_oe(oe_lo));

    supply_reset_seq #(.RELEASE_MS(REL), .ACTIVE_HIGH(1'b1)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .supply_ok_raw(supply_ok_raw),
        .wdt_expire(wdt_expire), .rst_level(lvl_hi), .rst_oe(oe_hi));

    // Reference model of the requirements: 0 low, 1 qualify, 2 run, 3 wdog hold
    logic m_s1, m_s2;
    int m_st, m_cnt;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_st <= 0; m_cnt <= 0;
        end else begin
            m_s1 <= supply_ok_raw;
            m_s2 <= m_s1;
            if (!m_s2) begin
                m_st <= 0; m_cnt <= 0;
            end else if (m_st == 0) begin
                m_st <= 1; m_cnt <= 0;
            end else if (m_st == 2) begin
                if (wdt_expire) m_st <= 3;
                m_cnt <= 0;
            end else if (wdt_expire) begin
                m_cnt <= 0;
            end else if (ms_tick) begin
                if (m_cnt + 1 == REL) begin m_st <= 2; m_cnt <= 0; end
                else m_cnt <= m_cnt + 1;
            end
        end
    end

    function automatic bit exp_active(int st);
        return st != 2;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_pads(string req);
        bit a = exp_active(m_st);
        check(oe_lo == a && oe_hi == a, req, {oe_lo, oe_hi}, {a, a});
        check(lvl_lo == !a && lvl_hi == a, {req, " R8"}, {lvl_lo, lvl_hi}, {!a, a});
    endtask

    // Count edges until reset releases; returns -1 on timeout
    task automatic measure(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (!oe_hi) return;
            if (n > 2000) begin n = -1; return; end
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog timeout actual=0 expected=1");
        summary();
    end

    initial begin
        int lat;
        void'($urandom(32'h5eed_1234));
        // R1: reset active during and after power-on reset
        supply_ok_raw = 1'b1; wdt_expire = 1'b1; ms_tick = 1'b1;
        repeat (3) @(negedge clk);
        check(oe_lo && !lvl_lo && lvl_hi, "R1 during por", oe_lo, 1);
        supply_ok_raw = 1'b0; wdt_expire = 1'b0;
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(oe_lo && oe_hi, "R1 after por supply low", oe_lo, 1);
        check_pads("R1");

        // R3 qualification latency, R9 strobes while low ignored
        wdt_expire = 1'b1; @(negedge clk); wdt_expire = 1'b0;
        @(negedge clk);
        wdt_expire = 1'b1; @(negedge clk); wdt_expire = 1'b0;
        supply_ok_raw = 1'b1;
        measure(lat);
        check(lat == REL + 3, "R3/R9 qualify latency", lat, REL + 3);
        check_pads("R3");

        // R5 watchdog hold
        repeat (3) @(negedge clk);
        wdt_expire = 1'b1; @(negedge clk); wdt_expire = 1'b0;
        check(oe_lo, "R5 strobe asserts", oe_lo, 1);
        measure(lat);
        check(lat == REL, "R5 hold length after strobe", lat + 1, REL + 1);

        // R6 second strobe restarts hold
        repeat (2) @(negedge clk);
        wdt_expire = 1'b1; @(negedge clk); wdt_expire = 1'b0;
        repeat (4) @(negedge clk);
        wdt_expire = 1'b1; @(negedge clk); wdt_expire = 1'b0;
        measure(lat);
        check(lat == REL, "R6 restarted hold", lat + 1, REL + 1);

        // R2 drop latency
        repeat (2) @(negedge clk);
        supply_ok_raw = 1'b0;
        @(negedge clk); @(negedge clk);
        check(!oe_lo, "R2 not yet after two edges", oe_lo, 0);
        @(negedge clk);
        check(oe_lo && oe_hi, "R2 asserted at third edge", oe_lo, 1);

        // R4 dip during countdown
        repeat (3) @(negedge clk);
        supply_ok_raw = 1'b1;
        repeat (8) @(negedge clk);
        supply_ok_raw = 1'b0; @(negedge clk); supply_ok_raw = 1'b1;
        measure(lat);
        check(lat == REL + 3, "R4 full delay after dip", lat, REL + 3);

        // R7 dip during watchdog hold
        repeat (2) @(negedge clk);
        wdt_expire = 1'b1; @(negedge clk); wdt_expire = 1'b0;
        repeat (3) @(negedge clk);
        supply_ok_raw = 1'b0; @(negedge clk); supply_ok_raw = 1'b1;
        measure(lat);
        check(lat == REL + 3, "R7 full qualify after dip in hold", lat, REL + 3);

        // R10 no tick no release
        supply_ok_raw = 1'b0; repeat (4) @(negedge clk);
        ms_tick = 1'b0; supply_ok_raw = 1'b1;
        repeat (REL * 4) @(negedge clk);
        check(oe_lo, "R10 no release without ticks", oe_lo, 1);
        ms_tick = 1'b1;
        measure(lat);
        check(lat == REL, "R10 ticks resume", lat, REL);

        // Random phase against the model
        for (int i = 0; i < 6000; i++) begin
            ms_tick = ($urandom_range(0, 3) == 0);
            wdt_expire = ($urandom_range(0, 60) == 0);
            if ($urandom_range(0, 150) == 0) supply_ok_raw = ~supply_ok_raw;
            else if (!supply_ok_raw && $urandom_range(0, 20) == 0) supply_ok_raw = 1'b1;
            @(negedge clk);
            check_pads("R2/R3/R4/R5/R6/R7 random model");
        end
        summary();
    end
endmodule